// File: doc/BRIEF.md
# Single-Channel DMA Engine with Three Bus-Acquisition Modes

This block moves bytes between system memory and one peripheral while the processor does not take part in the data path. Before a run, the processor writes a start address, a byte count, a mode and a direction in a single configuration write. The peripheral then raises its request line to start the run. Each moved byte is a single fly-by cycle. In that cycle the engine drives the memory address and strobes the source read and the destination write together. The byte passes from the source data bus to the shared transfer data output.

There are three ways to get the bus. In block mode the engine raises a hold request, waits for the processor's grant, and then moves the whole block in back-to-back cycles. In steal mode the engine pulls an inhibit line low. That line is ANDed with the system clock to make the processor clock, so the processor freezes for one byte per peripheral request. In interleave mode the processor keeps running. It marks cycles in which it will leave the bus free and marks the first cycle of each instruction. The engine uses a free cycle only when it has not already moved a byte in the current instruction.

The controller is a six-state machine:
- IDLE: waits for a nonzero count and a request.
- HOLD: hold is raised and the engine waits for the grant.
- FREEZE: inhibit is falling.
- WAITSLOT: interleave mode waits for a free slot.
- XFER: one byte moves.
- RELEASE: the engine gives the bus back.

The transitions are:
- IDLE to HOLD, FREEZE or WAITSLOT, picked by the mode.
- HOLD to XFER on grant.
- FREEZE to XFER after one cycle.
- WAITSLOT to XFER on a free-cycle mark.
- XFER to XFER (block, more bytes), XFER to WAITSLOT (interleave, more bytes), XFER to RELEASE (block last byte, or any steal byte), and XFER to IDLE (interleave last byte).
- RELEASE to IDLE, once the grant drops (block) or the request drops (steal).

Top module: `dmac_top`

## Requirements
- R1: Mode field values: 0 is block, 1 is steal, 2 is interleave, and 3 behaves as block. In block mode `hold` rises before any strobe, and no strobe appears until `hlda` is high. After that, all bytes move in consecutive cycles, so the last byte lands exactly count-1 cycles after the first.
- R2: `cfg_dir`=1 selects memory-to-peripheral: `mem_rd` and `io_wr` pulse together and `xfer_data` carries `mem_rdata`. `cfg_dir`=0 selects peripheral-to-memory: `io_rd` and `mem_wr` pulse together and `xfer_data` carries `io_rdata`. No strobe appears outside a cycle in which `dack` is high.
- R3: The first byte uses the loaded start address, and `mem_addr` rises by exactly one after every byte.
- R4: The internal count drops by one per byte. A run moves exactly the loaded number of bytes.
- R5: In block mode `hold` is low in the cycle after the last byte.
- R6: In steal mode `inhibit` is low during every byte cycle. Exactly one byte moves per request, even while `dreq` stays high, and another byte needs `dreq` to fall and rise again.
- R7: `inhibit` is high after reset and whenever the engine is not stealing. It changes only while `clk` is low.
- R8: In interleave mode `hold` stays low and `inhibit` stays high. A byte moves only in the cycle after one in which `bus_idle` was high. At most one byte moves between two `instr_start` marks; a byte in the marked cycle counts toward the new instruction.
- R9: `done` is low after reset. It rises after the last byte and stays high until the next accepted configuration write, which clears it.
- R10: A count of zero starts nothing: no `hold`, no `inhibit`, no strobe and no `done`, whatever `dreq` does.
- R11: A configuration write while a run is in progress is ignored. The run finishes with its original address and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe, taken only while idle |
| cfg_addr | input | ADDR_W | Start address |
| cfg_count | input | CNT_W | Byte count |
| cfg_mode | input | 2 | Bus-acquisition mode |
| cfg_dir | input | 1 | 1 memory-to-peripheral, 0 peripheral-to-memory |
| dreq | input | 1 | Peripheral request |
| dack | output | 1 | Peripheral acknowledge, high in each byte cycle |
| hold | output | 1 | Bus request to the processor |
| hlda | input | 1 | Bus grant from the processor |
| inhibit | output | 1 | Processor clock enable, ANDed with the system clock |
| bus_idle | input | 1 | Processor leaves the bus free in the next cycle |
| instr_start | input | 1 | First cycle of a processor instruction |
| mem_addr | output | ADDR_W | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Peripheral read strobe |
| io_wr | output | 1 | Peripheral write strobe |
| mem_rdata | input | DATA_W | Memory read data |
| io_rdata | input | DATA_W | Peripheral read data |
| xfer_data | output | DATA_W | Byte being moved |
| done | output | 1 | Run complete |

## Verification
Strobes, `dack`, `mem_addr` and `xfer_data` belong to the XFER cycle.
- In block mode the first XFER comes one cycle after `hlda` is seen high.
- In steal mode it comes two cycles after the request is seen.
- In interleave mode it comes one cycle after the `bus_idle` mark that allowed it.

`done` and the dropped `hold` are due in the cycle after the last byte. `inhibit` moves half a cycle after the state that calls for it.

The bench drives inputs one nanosecond after the rising edge and samples every output at the falling edge, so each sample sees settled state. It checks `inhibit` only several edges after it has had time to move.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        MODE_BLOCK  = 2'd0,
        MODE_STEAL  = 2'd1,
        MODE_ILEAVE = 2'd2,
        MODE_RSVD   = 2'd3
    } dma_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_FREEZE,
        ST_WAITSLOT,
        ST_XFER,
        ST_RELEASE
    } dma_state_e;

endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              accept,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_dir,
    input  logic              step,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_count,
    output dma_mode_e         cur_mode,
    output logic              cur_dir,
    output logic              done,
    output logic              armed,
    output logic              last
);

    localparam logic [ADDR_W-1:0] ADDR_ONE = 1;
    localparam logic [CNT_W-1:0]  CNT_ONE  = 1;
    localparam logic [CNT_W-1:0]  CNT_ZERO = '0;

    dma_mode_e mode_in;

    // The reserved encoding falls back to block transfer.
    always_comb begin
        mode_in = dma_mode_e'(cfg_mode);
        if (mode_in == MODE_RSVD) mode_in = MODE_BLOCK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            cur_count <= CNT_ZERO;
            cur_mode  <= MODE_BLOCK;
            cur_dir   <= 1'b0;
            done      <= 1'b0;
        end else if (cfg_we && accept) begin
            cur_addr  <= cfg_addr;
            cur_count <= cfg_count;
            cur_mode  <= mode_in;
            cur_dir   <= cfg_dir;
            done      <= 1'b0;
        end else if (step) begin
            cur_addr  <= cur_addr + ADDR_ONE;
            cur_count <= cur_count - CNT_ONE;
            if (cur_count == CNT_ONE) done <= 1'b1;
        end
    end

    assign armed = (cur_count != CNT_ZERO);
    assign last  = (cur_count == CNT_ONE);

endmodule

// File: rtl/dma_fsm.sv
module dma_fsm
    import dma_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      armed,
    input  logic      last,
    input  dma_mode_e mode,
    input  logic      dreq,
    input  logic      hlda,
    input  logic      bus_idle,
    input  logic      instr_start,
    output logic      step,
    output logic      hold,
    output logic      inhibit_req,
    output logic      idle
);

    dma_state_e state, state_nx;
    logic       slot_used;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // One interleave byte per instruction cycle; a byte in the marked cycle counts for the new one.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                     slot_used <= 1'b0;
        else if (state == ST_XFER && mode == MODE_ILEAVE) slot_used <= 1'b1;
        else if (instr_start)                           slot_used <= 1'b0;
    end

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (armed && dreq) begin
                    unique case (mode)
                        MODE_STEAL:  state_nx = ST_FREEZE;
                        MODE_ILEAVE: state_nx = ST_WAITSLOT;
                        default:     state_nx = ST_HOLD;
                    endcase
                end
            end
            ST_HOLD:     if (hlda) state_nx = ST_XFER;
            ST_FREEZE:   state_nx = ST_XFER;
            ST_WAITSLOT: if (bus_idle && (!slot_used || instr_start)) state_nx = ST_XFER;
            ST_XFER: begin
                unique case (mode)
                    MODE_STEAL:  state_nx = ST_RELEASE;
                    MODE_ILEAVE: state_nx = last ? ST_IDLE : ST_WAITSLOT;
                    default:     state_nx = last ? ST_RELEASE : ST_XFER;
                endcase
            end
            ST_RELEASE: begin
                if (mode == MODE_STEAL) begin
                    if (!dreq) state_nx = ST_IDLE;
                end else if (!hlda) begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs decoded from the registered state.
    always_comb begin
        step        = (state == ST_XFER);
        idle        = (state == ST_IDLE);
        hold        = (mode == MODE_BLOCK) && (state == ST_HOLD || state == ST_XFER);
        inhibit_req = !((mode == MODE_STEAL) && (state == ST_FREEZE || state == ST_XFER));
    end

endmodule

// File: rtl/dma_inhibit.sv
module dma_inhibit (
    input  logic clk,
    input  logic rst_n,
    input  logic inhibit_req,
    output logic inhibit
);

    // Retimed on the falling edge so the gated processor clock only loses whole pulses.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) inhibit <= 1'b1;
        else        inhibit <= inhibit_req;
    end

endmodule

// File: rtl/dmac_top.sv
module dmac_top
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_dir,
    input  logic              dreq,
    output logic              dack,
    output logic              hold,
    input  logic              hlda,
    output logic              inhibit,
    input  logic              bus_idle,
    input  logic              instr_start,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              io_rd,
    output logic              io_wr,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] io_rdata,
    output logic [DATA_W-1:0] xfer_data,
    output logic              done
);

    logic [CNT_W-1:0] cur_count;
    dma_mode_e        cur_mode;
    logic             cur_dir;
    logic             armed, last, step, idle, inhibit_req;

    dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .accept    (idle),
        .cfg_addr  (cfg_addr),
        .cfg_count (cfg_count),
        .cfg_mode  (cfg_mode),
        .cfg_dir   (cfg_dir),
        .step      (step),
        .cur_addr  (mem_addr),
        .cur_count (cur_count),
        .cur_mode  (cur_mode),
        .cur_dir   (cur_dir),
        .done      (done),
        .armed     (armed),
        .last      (last)
    );

    dma_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .armed       (armed),
        .last        (last),
        .mode        (cur_mode),
        .dreq        (dreq),
        .hlda        (hlda),
        .bus_idle    (bus_idle),
        .instr_start (instr_start),
        .step        (step),
        .hold        (hold),
        .inhibit_req (inhibit_req),
        .idle        (idle)
    );

    dma_inhibit u_inh (
        .clk         (clk),
        .rst_n       (rst_n),
        .inhibit_req (inhibit_req),
        .inhibit     (inhibit)
    );

    // Fly-by data path: the source read and the destination write share the byte cycle.
    always_comb begin
        dack      = step;
        mem_rd    = step &&  cur_dir;
        io_wr     = step &&  cur_dir;
        io_rd     = step && !cur_dir;
        mem_wr    = step && !cur_dir;
        xfer_data = cur_dir ? mem_rdata : io_rdata;
    end

endmodule

// File: rtl/dma_checker.sv
module dma_checker
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              dack,
    input  logic              hold,
    input  logic              hlda,
    input  logic              inhibit,
    input  logic              bus_idle,
    input  logic              mem_rd,
    input  logic              mem_wr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [CNT_W-1:0]  count,
    input  dma_mode_e         mode,
    input  logic              done
);

    localparam logic [ADDR_W-1:0] A_ONE = 1;
    localparam logic [CNT_W-1:0]  C_ONE = 1;

    AST_GRANT_BEFORE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr || io_rd || io_wr) && mode == MODE_BLOCK |-> hold && hlda); // R1

    AST_STROBE_PAIRING: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr || io_rd || io_wr) |-> dack && $countones({mem_rd, mem_wr}) == 1
        && $countones({io_rd, io_wr}) == 1 && mem_rd == io_wr); // R2

    AST_ADDR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        dack |=> mem_addr == $past(mem_addr) + A_ONE); // R3

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        dack |=> count == $past(count) - C_ONE); // R4

    AST_RELEASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dack && count == C_ONE && mode == MODE_BLOCK |=> !hold); // R5

    AST_STEAL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        dack && mode == MODE_STEAL |-> !inhibit); // R6

    AST_INHIBIT_ONLY_STEAL: assert property (@(posedge clk) disable iff (!rst_n)
        !inhibit |-> mode == MODE_STEAL); // R7

    AST_ILEAVE_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        dack && mode == MODE_ILEAVE |-> $past(bus_idle) && inhibit && !hold); // R8

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done && !cfg_we |=> done); // R9

    AST_ZERO_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        count == '0 |-> !dack); // R10

    always @(inhibit) begin
        if (rst_n) begin
            AST_INHIBIT_LOW_PHASE: assert (!clk); // R7
        end
    end

endmodule

bind dmac_top dma_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .dack     (dack),
    .hold     (hold),
    .hlda     (hlda),
    .inhibit  (inhibit),
    .bus_idle (bus_idle),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .mem_addr (mem_addr),
    .count    (cur_count),
    .mode     (cur_mode),
    .done     (done)
);

// File: tb/tb_dmac_top.sv
module tb_dmac_top;

    localparam int AW = 16;
    localparam int CW = 12;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [CW-1:0] cfg_count = '0;
    logic [1:0]    cfg_mode = '0;
    logic          cfg_dir = 1'b0;
    logic          dreq = 1'b0;
    logic          hlda = 1'b0;
    logic          bus_idle = 1'b0;
    logic          instr_start = 1'b0;
    logic          dack, hold, inhibit, mem_rd, mem_wr, io_rd, io_wr, done;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata, io_rdata, xfer_data;

    dmac_top #(.ADDR_W(AW), .CNT_W(CW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_count(cfg_count), .cfg_mode(cfg_mode), .cfg_dir(cfg_dir),
        .dreq(dreq), .dack(dack), .hold(hold), .hlda(hlda), .inhibit(inhibit),
        .bus_idle(bus_idle), .instr_start(instr_start), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
        .mem_rdata(mem_rdata), .io_rdata(io_rdata), .xfer_data(xfer_data), .done(done)
    );

    always #4 clk = ~clk;   // 125 MHz

    int n_chk = 0, n_fail = 0, cyc = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic logic [7:0] mem_pat(input int a);
        return 8'((a * 13) + 5);
    endfunction
    function automatic logic [7:0] io_pat(input int i);
        return 8'hA0 ^ 8'(i * 29);
    endfunction

    // Memory and peripheral models
    logic [7:0] mem [0:255];
    logic [7:0] shadow [0:255];
    int io_idx = 0;
    assign mem_rdata = mem[mem_addr[7:0]];
    assign io_rdata  = io_pat(io_idx);
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[7:0]] <= xfer_data;
        if (io_rd)  io_idx <= io_idx + 1;
    end

    // Processor bus-grant model
    int hold_lat = 0, lat_cnt = 0;
    always @(posedge clk) begin
        #1;
        if (!hold) begin
            hlda = 1'b0; lat_cnt = 0;
        end else if (!hlda) begin
            if (lat_cnt >= hold_lat) hlda = 1'b1;
            else lat_cnt++;
        end
    end

    // Processor idle-slot model
    bit ilv_drv = 0;
    always @(posedge clk) begin
        #1;
        if (ilv_drv) begin
            bus_idle    = ($urandom % 4) != 0;
            instr_start = ($urandom % 5) == 0;
        end else begin
            bus_idle = 1'b0; instr_start = 1'b0;
        end
    end

    // Falling-edge monitor with expected-value tracking
    int          exp_mode = 0, exp_io = 0, bytes = 0, req_bytes = 0, ic_bytes = 0;
    int          first_cyc = 0, last_cyc = 0;
    bit          exp_dir = 0, prev_idle = 0;
    logic [AW-1:0] exp_addr = '0;
    int          exp_cnt = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (instr_start) ic_bytes = 0;
            if (dack) begin
                logic [7:0] ed;
                chk(mem_addr == exp_addr, "R3 address", mem_addr, exp_addr);
                chk(exp_cnt > 0, "R4 extra byte", bytes, exp_cnt);
                chk({mem_rd, io_wr, io_rd, mem_wr} == (exp_dir ? 4'b1100 : 4'b0011),
                    "R2 strobes", {mem_rd, io_wr, io_rd, mem_wr}, exp_dir ? 4'b1100 : 4'b0011);
                ed = exp_dir ? shadow[exp_addr[7:0]] : io_pat(exp_io);
                chk(xfer_data == ed, "R2 data", xfer_data, ed);
                if (!exp_dir) begin
                    shadow[exp_addr[7:0]] = ed;
                    exp_io++;
                end
                case (exp_mode)
                    1: begin
                        chk(!inhibit, "R6 inhibit low in byte cycle", inhibit, 0);
                        req_bytes++;
                    end
                    2: begin
                        chk(prev_idle && !hold && inhibit, "R8 free slot",
                            {prev_idle, hold, inhibit}, 3'b101);
                        ic_bytes++;
                        chk(ic_bytes <= 1, "R8 one per instruction", ic_bytes, 1);
                    end
                    default: begin
                        chk(hold && hlda, "R1 granted", {hold, hlda}, 2'b11);
                        if (bytes == 0) first_cyc = cyc;
                        last_cyc = cyc;
                    end
                endcase
                exp_addr = exp_addr + 1'b1;
                exp_cnt--;
                bytes++;
            end else if (mem_rd || mem_wr || io_rd || io_wr) begin
                chk(0, "R2 strobe without acknowledge", {mem_rd, mem_wr, io_rd, io_wr}, 0);
            end
            prev_idle = bus_idle;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL R4 watchdog actual=%0d expected=<150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Inhibit edge placement, seen at the port
    always @(inhibit) begin
        if (rst_n) chk(!clk, "R7 inhibit edge in low phase", clk, 0);
    end

    task automatic load(input [1:0] m, input bit d, input [AW-1:0] a, input [CW-1:0] c);
        @(posedge clk); #1;
        cfg_we = 1; cfg_mode = m; cfg_dir = d; cfg_addr = a; cfg_count = c;
        @(posedge clk); #1;
        cfg_we = 0;
    endtask

    task automatic wait_dack();
        for (int k = 0; k < 400 && !dack; k++) @(negedge clk);
    endtask

    task automatic run_xfer(input [1:0] m, input bit d, input [AW-1:0] a, input int c,
                            input int lat, input bit poke);
        exp_mode = (m == 2'd3) ? 0 : int'(m);
        exp_dir = d; exp_addr = a; exp_cnt = c; bytes = 0; hold_lat = lat;
        load(m, d, a, CW'(c));
        if (exp_mode == 1) begin
            for (int i = 0; i < c; i++) begin
                req_bytes = 0;
                @(posedge clk); #1 dreq = 1;
                @(negedge clk);
                wait_dack();
                repeat (4) @(negedge clk);
                chk(req_bytes == 1, "R6 one byte per request", req_bytes, 1);
                chk(inhibit == 1'b1, "R7 inhibit restored", inhibit, 1);
                @(posedge clk); #1 dreq = 0;
                repeat (2) @(posedge clk);
            end
        end else if (exp_mode == 2) begin
            ilv_drv = 1;
            @(posedge clk); #1 dreq = 1;
        end else begin
            @(posedge clk); #1 dreq = 1;
            if (poke) begin
                for (int k = 0; k < 50 && !hold; k++) @(negedge clk);
                load(2'd1, ~d, 16'h0099, 12'd7);   // R11: ignored while busy
            end
            @(negedge clk);
            wait_dack();
            @(posedge clk); #1 dreq = 0;
        end
        for (int k = 0; k < 2000 && !done; k++) @(negedge clk);
        @(negedge clk);
        if (exp_mode == 0) begin
            chk(hold == 1'b0, "R5 hold released", hold, 0);
            chk(last_cyc - first_cyc == c - 1, "R1 back-to-back", last_cyc - first_cyc, c - 1);
        end
        if (exp_mode == 2) chk(!hold && inhibit, "R8 processor untouched", {hold, inhibit}, 2'b01);
        ilv_drv = 0;
        @(posedge clk); #1 dreq = 0;
        @(negedge clk);
        chk(done == 1'b1, "R9 done set", done, 1);
        chk(bytes == c, poke ? "R11 original count kept" : "R4 byte total", bytes, c);
        chk(mem_addr == a + AW'(c), poke ? "R11 original address kept" : "R3 final address",
            mem_addr, a + AW'(c));
        if (!d) for (int j = 0; j < c; j++)
            chk(mem[8'(a + j)] == shadow[8'(a + j)], "R2 memory written",
                mem[8'(a + j)], shadow[8'(a + j)]);
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) begin
            mem[i] = mem_pat(i);
            shadow[i] = mem_pat(i);
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // Reset state
        chk(inhibit == 1'b1, "R7 reset inhibit", inhibit, 1);
        chk(hold == 1'b0, "R1 reset hold", hold, 0);
        chk(done == 1'b0, "R9 reset done", done, 0);
        chk(mem_addr == '0, "R3 reset address", mem_addr, 0);

        // Directed cases
        run_xfer(2'd0, 1'b1, 16'h0010, 5, 2, 0);   // block, memory to peripheral
        run_xfer(2'd0, 1'b0, 16'h0030, 4, 0, 0);   // block, peripheral to memory
        run_xfer(2'd1, 1'b1, 16'h0050, 3, 0, 0);   // steal
        run_xfer(2'd2, 1'b0, 16'h0070, 6, 0, 0);   // interleave
        run_xfer(2'd0, 1'b1, 16'h0040, 3, 6, 1);   // write while busy
        run_xfer(2'd3, 1'b0, 16'h00F0, 1, 1, 0);   // reserved mode as block, single byte

        // Zero count: reload clears done, nothing starts
        exp_cnt = 0; bytes = 0;
        load(2'd0, 1'b1, 16'h0020, 12'd0);
        @(negedge clk);
        chk(done == 1'b0, "R9 cleared by reload", done, 0);
        @(posedge clk); #1 dreq = 1;
        repeat (20) @(negedge clk);
        chk(bytes == 0 && !hold && inhibit && !done, "R10 zero count idle",
            {bytes[3:0], hold, inhibit, done}, 6'b000010);
        @(posedge clk); #1 dreq = 0;

        // Random runs
        for (int it = 0; it < 12; it++) begin
            logic [1:0] m;
            m = 2'($urandom % 4);
            run_xfer(m, 1'($urandom % 2), 16'($urandom), 1 + ($urandom % 7), $urandom % 4, 0);
        end

        repeat (4) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule